// File: doc/BRIEF.md
# Dual-Line Serial Flash Read Responder

This block is the memory-side end of a two-wire serial read link. Each bus transaction begins when chip select goes low. The host first sends an 8-bit command and then a 24-bit address, both two bits per clock on a pair of data lines. The responder then lets a fixed run of idle clocks pass, which covers its internal access time. After that it drives read data back on the same two lines, two bits per clock, for as long as chip select stays low.

Three command codes select the ordinary fast read from the main array, and they behave identically. A fourth code reads a separate 64-byte one-time-programmable (OTP) area. The main array is a small fixed-content array addressed by the low address bits.

The module does not drive the pins directly. It presents output values and output enables, and the pad ring builds the tristate buffers from them. Inputs are sampled on the rising edge of the serial clock. Outputs change on the falling edge.

Top module: `dio_rd_responder`

## Requirements
- R1: The command takes 4 clocks, two bits per clock, most significant pair first. In each pair, line 1 carries the odd bit (7, 5, 3, 1) and line 0 carries the even bit. A command sent with its pairs reversed or its lines swapped is not recognised.
- R2: Codes 0Bh, 3Bh and BBh each start the same main-array read and give identical data for the same address.
- R3: Code 4Bh reads the OTP area at offset address[5:0]. The OTP byte at offset o is 8'hC0 | o.
- R4: The address takes 12 clocks, most significant pair first, with line 1 carrying the odd bits 23..1 and line 0 the even bits 22..0. The main array index is address[9:0] (MainAddrBits = 10). Higher bits are ignored. The main byte at index i, zero-extended to 16 bits, is i[7:0] ^ i[15:8] ^ 8'hC3.
- R5: Exactly DummyCycles (default 8) idle clocks follow the last address clock. Both output enables stay low from chip select low until the first data clock.
- R6: Each byte takes 4 clocks. Line 1 carries bits 7, 5, 3, 1 and line 0 carries bits 6, 4, 2, 0, high pair first. Output changes on the falling edge. Both enables are high throughout the data phase and never differ from each other.
- R7: A main read streams successive bytes with the index rising by one per byte. After index 1023 it wraps to 0.
- R8: An OTP read streams successive bytes within the 64-byte area. After offset 63 it wraps to 0, and the upper address bits are left untouched.
- R9: When chip select goes high, both enables drop at once without a clock edge. The next transaction then starts again with command capture.
- R10: An unrecognised command keeps both enables low for the rest of the transaction, whatever follows on the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the host |
| csN | input | 1 | Chip select, active low; high resets the transaction |
| dqIn | input | 2 | Values seen on data lines 1 and 0 |
| dqOut | output | 2 | Values to drive onto data lines 1 and 0 |
| dqOe | output | 2 | Output enables for data lines 1 and 0 |

## Verification
The hardest situation to reach from the ports is an abort in the middle of a byte. Chip select has to rise while the lines are being driven, with no clock edge to move the state. The stimulus stops the clocked stepping halfway through a byte, raises chip select between edges and samples the enables a fraction of a nanosecond later. It then starts a fresh read at once to show that command capture restarted. Both wrap points are reached by table entries whose start addresses sit two bytes below the top of each area. This lets a short burst cross the boundary.

// File: rtl/dio_rd_pkg.sv
`timescale 1ns/1ps
package dio_rd_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_REJECT
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       shiftOpc;
    logic       shiftAddr;
    logic       incAddr;
    logic       drive;
    logic       otpSel;
    logic [1:0] pairSel;
  } strobes_t;

  localparam logic [7:0] OPC_FAST_A = 8'h0B;
  localparam logic [7:0] OPC_FAST_B = 8'h3B;
  localparam logic [7:0] OPC_FAST_C = 8'hBB;
  localparam logic [7:0] OPC_OTP    = 8'h4B;

  localparam int OtpAddrBits = 6;

  function automatic logic isFastRead(input logic [7:0] op);
    return (op == OPC_FAST_A) || (op == OPC_FAST_B) || (op == OPC_FAST_C);
  endfunction

  // fixed content of the main array, computed instead of stored
  function automatic logic [7:0] mainContent(input logic [15:0] idx);
    return idx[7:0] ^ idx[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [7:0] otpContent(input logic [OtpAddrBits-1:0] off);
    return 8'hC0 | {2'b00, off};
  endfunction

endpackage

// File: rtl/dio_rd_ctrl.sv
`timescale 1ns/1ps
module dio_rd_ctrl
  import dio_rd_pkg::*;
#(
  parameter int AddrPairs   = 12,
  parameter int DummyCycles = 8
) (
  input  logic       clk,
  input  logic       csN,
  input  logic [7:0] opcNext,
  output strobes_t   strobes,
  output phase_e     phase
);

  localparam int OpcPairs = 4;
  localparam int CntMax   = (AddrPairs > DummyCycles) ? AddrPairs : DummyCycles;
  localparam int CntW     = $clog2(CntMax + 1);

  phase_e          phaseQ;
  logic [CntW-1:0] cnt;
  logic [1:0]      pairQ;
  logic            otpQ;

  // rising-edge sequencing; chip select high clears the transaction
  always_ff @(posedge clk or posedge csN) begin
    if (csN) begin
      phaseQ <= PH_OPC;
      cnt    <= '0;
      pairQ  <= '0;
      otpQ   <= 1'b0;
    end else begin
      case (phaseQ)
        PH_OPC: begin
          if (cnt == CntW'(OpcPairs - 1)) begin
            cnt <= '0;
            if (isFastRead(opcNext)) begin
              phaseQ <= PH_ADDR;
              otpQ   <= 1'b0;
            end else if (opcNext == OPC_OTP) begin
              phaseQ <= PH_ADDR;
              otpQ   <= 1'b1;
            end else begin
              phaseQ <= PH_REJECT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt == CntW'(AddrPairs - 1)) begin
            cnt    <= '0;
            phaseQ <= PH_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt == CntW'(DummyCycles - 1)) begin
            cnt    <= '0;
            pairQ  <= '0;
            phaseQ <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: begin
          pairQ <= pairQ + 2'd1;
        end
        default: begin
          phaseQ <= PH_REJECT;
        end
      endcase
    end
  end

  always_comb begin
    strobes.shiftOpc  = (phaseQ == PH_OPC);
    strobes.shiftAddr = (phaseQ == PH_ADDR);
    strobes.incAddr   = (phaseQ == PH_DATA) && (pairQ == 2'd3);
    strobes.drive     = (phaseQ == PH_DATA);
    strobes.otpSel    = otpQ;
    strobes.pairSel   = pairQ;
  end

  assign phase = phaseQ;

endmodule

// File: rtl/dio_rd_datapath.sv
`timescale 1ns/1ps
module dio_rd_datapath
  import dio_rd_pkg::*;
#(
  parameter int AddrBits     = 24,
  parameter int MainAddrBits = 10
) (
  input  logic                clk,
  input  logic                csN,
  input  logic [1:0]          dqIn,
  input  strobes_t            strobes,
  output logic [7:0]          opcNext,
  output logic [AddrBits-1:0] curAddr,
  output logic [1:0]          dqOut,
  output logic [1:0]          dqOe
);

  logic [5:0]          opcSr;
  logic [AddrBits-1:0] addrQ;
  logic [15:0]         mainIdx;
  logic [7:0]          curByte;
  logic [1:0]          pairNow;
  logic [1:0]          dqQ;
  logic [1:0]          oeQ;

  assign opcNext = {opcSr, dqIn};

  // command and address shift, burst address advance
  always_ff @(posedge clk or posedge csN) begin
    if (csN) begin
      opcSr <= '0;
      addrQ <= '0;
    end else begin
      if (strobes.shiftOpc) begin
        opcSr <= opcNext[5:0];
      end
      if (strobes.shiftAddr) begin
        addrQ <= {addrQ[AddrBits-3:0], dqIn};
      end else if (strobes.incAddr) begin
        if (strobes.otpSel) begin
          addrQ[OtpAddrBits-1:0] <= addrQ[OtpAddrBits-1:0] + 1'b1;
        end else begin
          addrQ[MainAddrBits-1:0] <= addrQ[MainAddrBits-1:0] + 1'b1;
        end
      end
    end
  end

  assign mainIdx = 16'(addrQ[MainAddrBits-1:0]);

  always_comb begin
    if (strobes.otpSel) begin
      curByte = otpContent(addrQ[OtpAddrBits-1:0]);
    end else begin
      curByte = mainContent(mainIdx);
    end
    case (strobes.pairSel)
      2'd0:    pairNow = curByte[7:6];
      2'd1:    pairNow = curByte[5:4];
      2'd2:    pairNow = curByte[3:2];
      default: pairNow = curByte[1:0];
    endcase
  end

  // falling-edge launch; chip select high releases the lines at once
  always_ff @(negedge clk or posedge csN) begin
    if (csN) begin
      dqQ <= '0;
      oeQ <= '0;
    end else begin
      oeQ <= {2{strobes.drive}};
      dqQ <= strobes.drive ? pairNow : 2'b00;
    end
  end

  assign curAddr = addrQ;
  assign dqOut   = dqQ;
  assign dqOe    = oeQ;

endmodule

// File: rtl/dio_rd_responder.sv
`timescale 1ns/1ps
module dio_rd_responder
  import dio_rd_pkg::*;
#(
  parameter int MainAddrBits = 10,
  parameter int DummyCycles  = 8
) (
  input  logic       clk,
  input  logic       csN,
  input  logic [1:0] dqIn,
  output logic [1:0] dqOut,
  output logic [1:0] dqOe
);

  localparam int AddrBits  = 24;
  localparam int AddrPairs = AddrBits / 2;

  strobes_t            strobes;
  phase_e              phase;
  logic [7:0]          opcNext;
  logic [AddrBits-1:0] curAddr;

  dio_rd_ctrl #(
    .AddrPairs  (AddrPairs),
    .DummyCycles(DummyCycles)
  ) u_ctrl (
    .clk    (clk),
    .csN    (csN),
    .opcNext(opcNext),
    .strobes(strobes),
    .phase  (phase)
  );

  dio_rd_datapath #(
    .AddrBits    (AddrBits),
    .MainAddrBits(MainAddrBits)
  ) u_dp (
    .clk    (clk),
    .csN    (csN),
    .dqIn   (dqIn),
    .strobes(strobes),
    .opcNext(opcNext),
    .curAddr(curAddr),
    .dqOut  (dqOut),
    .dqOe   (dqOe)
  );

endmodule

// File: rtl/dio_rd_checker.sv
`timescale 1ns/1ps
module dio_rd_checker
  import dio_rd_pkg::*;
#(
  parameter int DummyCycles = 8,
  parameter int AddrBits    = 24
) (
  input logic                clk,
  input logic                csN,
  input phase_e              phase,
  input strobes_t            strobes,
  input logic [AddrBits-1:0] curAddr,
  input logic [1:0]          dqOe
);

  int opcEdges;
  int addrEdges;
  int dumEdges;

  always_ff @(posedge clk or posedge csN) begin
    if (csN) begin
      opcEdges  <= 0;
      addrEdges <= 0;
      dumEdges  <= 0;
    end else begin
      if (phase == PH_OPC)   opcEdges  <= opcEdges + 1;
      if (phase == PH_ADDR)  addrEdges <= addrEdges + 1;
      if (phase == PH_DUMMY) dumEdges  <= dumEdges + 1;
    end
  end

  p_opc_len_r1: assert property (@(posedge clk) disable iff (csN)
    (phase == PH_ADDR) |-> (opcEdges == 4));

  p_addr_len_r4: assert property (@(posedge clk) disable iff (csN)
    (phase == PH_DUMMY) |-> (addrEdges == AddrBits / 2));

  p_dummy_len_r5: assert property (@(posedge clk) disable iff (csN)
    (phase == PH_DATA) |-> (dumEdges == DummyCycles));

  p_quiet_before_data_r5: assert property (@(posedge clk) disable iff (csN)
    (phase != PH_DATA) |-> (dqOe == 2'b00));

  p_drive_in_data_r6: assert property (@(posedge clk) disable iff (csN)
    (phase == PH_DATA) |=> (dqOe == 2'b11));

  p_enables_paired_r6: assert property (@(posedge clk) disable iff (csN)
    (dqOe == 2'b00) || (dqOe == 2'b11));

  p_otp_wrap_r8: assert property (@(posedge clk) disable iff (csN)
    (strobes.incAddr && strobes.otpSel && (curAddr[5:0] == 6'h3F))
      |=> (curAddr[5:0] == 6'h00));

  p_otp_upper_kept_r8: assert property (@(posedge clk) disable iff (csN)
    (strobes.incAddr && strobes.otpSel) |=> $stable(curAddr[AddrBits-1:6]));

  p_reject_sticky_r10: assert property (@(posedge clk) disable iff (csN)
    (phase == PH_REJECT) |=> ((phase == PH_REJECT) && (dqOe == 2'b00)));

endmodule

bind dio_rd_responder dio_rd_checker #(
  .DummyCycles(DummyCycles),
  .AddrBits   (AddrBits)
) u_chk (
  .clk    (clk),
  .csN    (csN),
  .phase  (phase),
  .strobes(strobes),
  .curAddr(curAddr),
  .dqOe   (dqOe)
);

// File: tb/test_dio_rd_responder.sv
`timescale 1ns/1ps
module test_dio_rd_responder;

  localparam int MainAddrBits = 10;
  localparam int DummyCycles  = 8;
  localparam int NumVec       = 7;

  // {opcode[47:40], address[39:16], byte count[15:8], expected first byte[7:0]}
  localparam logic [47:0] VEC [NumVec] = '{
    {8'h0B, 24'h000000, 8'd2, 8'hC3},
    {8'h3B, 24'h000155, 8'd2, 8'h97},
    {8'hBB, 24'h0003FE, 8'd3, 8'h3E},
    {8'h0B, 24'hABC123, 8'd2, 8'hE1},
    {8'h4B, 24'h000005, 8'd2, 8'hC5},
    {8'h4B, 24'h00003E, 8'd3, 8'hFE},
    {8'h4B, 24'h000140, 8'd1, 8'hC0}
  };

  logic       clk = 1'b0;
  logic       csN = 1'b0;
  logic [1:0] dqIn = 2'b00;
  logic [1:0] dqOut;
  logic [1:0] dqOe;

  int         nChecks = 0;
  int         nFails  = 0;
  logic [7:0] gotBytes [8];
  logic       cmdQuiet;
  logic       dataDriven;

  always #2.5 clk = ~clk;

  dio_rd_responder #(
    .MainAddrBits(MainAddrBits),
    .DummyCycles (DummyCycles)
  ) i_dio_rd_responder (
    .clk  (clk),
    .csN  (csN),
    .dqIn (dqIn),
    .dqOut(dqOut),
    .dqOe (dqOe)
  );

  function automatic logic [7:0] modelMain(input logic [23:0] a);
    logic [15:0] idx;
    idx = 16'(a[MainAddrBits-1:0]);
    return idx[7:0] ^ idx[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [7:0] modelOtp(input logic [23:0] a);
    return 8'hC0 | {2'b00, a[5:0]};
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive a pair, observe what the host sees at the rising edge
  task automatic step(input logic [1:0] p, output logic [1:0] o, output logic [1:0] e);
    dqIn = p;
    @(negedge clk);
    #1;
    o = dqOut;
    e = dqOe;
    @(posedge clk);
    #1;
  endtask

  task automatic startCs();
    @(posedge clk);
    #1;
    csN = 1'b0;
  endtask

  task automatic endCs();
    csN = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic sendHeader(input logic [7:0] opc, input logic [23:0] addr);
    logic [1:0] o;
    logic [1:0] e;
    cmdQuiet = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(opc[7-2*i -: 2], o, e);
      if (e !== 2'b00) cmdQuiet = 1'b0;
    end
    for (int i = 0; i < 12; i++) begin
      step(addr[23-2*i -: 2], o, e);
      if (e !== 2'b00) cmdQuiet = 1'b0;
    end
    for (int i = 0; i < DummyCycles; i++) begin
      step(2'b00, o, e);
      if (e !== 2'b00) cmdQuiet = 1'b0;
    end
  endtask

  task automatic readBytes(input int n);
    logic [1:0] o;
    logic [1:0] e;
    logic [7:0] by;
    dataDriven = 1'b1;
    for (int b = 0; b < n; b++) begin
      by = '0;
      for (int k = 0; k < 4; k++) begin
        step(2'b00, o, e);
        by = {by[5:0], o};
        if (e !== 2'b11) dataDriven = 1'b0;
      end
      gotBytes[b] = by;
    end
  endtask

  // after a command only: count clocks on which any enable rises
  task automatic watchQuiet(input int n, output logic quiet);
    logic [1:0] o;
    logic [1:0] e;
    quiet = 1'b1;
    for (int i = 0; i < n; i++) begin
      step(2'b11 ^ 2'(i), o, e);
      if (e !== 2'b00) quiet = 1'b0;
    end
  endtask

  task automatic sendOpcOnly(input logic [7:0] opc);
    logic [1:0] o;
    logic [1:0] e;
    for (int i = 0; i < 4; i++) begin
      step(opc[7-2*i -: 2], o, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired: actual running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic       quiet;
    logic [7:0] opc;
    logic [23:0] addr;
    int         n;
    logic [7:0] expB;
    logic [1:0] o;
    logic [1:0] e;

    #1 csN = 1'b1;

    // reset state: chip select high keeps the lines released
    repeat (3) @(posedge clk);
    #1;
    checkVal("R9", "idle enables", 32'(dqOe), 32'h0);
    checkVal("R9", "idle data", 32'(dqOut), 32'h0);

    // table of reads: R2 R3 R4 R7 R8
    for (int v = 0; v < NumVec; v++) begin
      opc  = VEC[v][47:40];
      addr = VEC[v][39:16];
      n    = int'(VEC[v][15:8]);
      startCs();
      sendHeader(opc, addr);
      readBytes(n);
      endCs();
      checkVal("R5", "enables low before data", 32'(cmdQuiet), 32'h1);
      checkVal("R6", "enables high during data", 32'(dataDriven), 32'h1);
      checkVal((opc == 8'h4B) ? "R3" : "R2 R4", "first byte", 32'(gotBytes[0]),
               32'(VEC[v][7:0]));
      for (int b = 1; b < n; b++) begin
        expB = (opc == 8'h4B) ? modelOtp(addr + 24'(b)) : modelMain(addr + 24'(b));
        checkVal((opc == 8'h4B) ? "R8" : "R7", "streamed byte", 32'(gotBytes[b]),
                 32'(expB));
      end
    end

    // R10: unrecognised command stays silent
    startCs();
    sendOpcOnly(8'h9F);
    watchQuiet(40, quiet);
    endCs();
    checkVal("R10", "unknown command silent", 32'(quiet), 32'h1);

    // R1: fast-read code sent with pairs reversed (E0h) is not a read
    startCs();
    sendOpcOnly(8'hE0);
    watchQuiet(30, quiet);
    endCs();
    checkVal("R1", "reversed pair order rejected", 32'(quiet), 32'h1);

    // R1: fast-read code sent with lines swapped (07h) is not a read
    startCs();
    sendOpcOnly(8'h07);
    watchQuiet(30, quiet);
    endCs();
    checkVal("R1", "swapped lines rejected", 32'(quiet), 32'h1);

    // R9: abort halfway through a driven byte, release without a clock edge
    startCs();
    sendHeader(8'h0B, 24'h000010);
    readBytes(1);
    step(2'b00, o, e);
    step(2'b00, o, e);
    checkVal("R9", "driving before abort", 32'(dqOe), 32'h3);
    csN = 1'b1;
    #0.5;
    checkVal("R9", "released at once", 32'(dqOe), 32'h0);
    @(posedge clk);
    #1;
    startCs();
    sendHeader(8'h4B, 24'h000021);
    readBytes(1);
    endCs();
    checkVal("R9", "restart after data abort", 32'(gotBytes[0]), 32'hE1);

    // R9: abort during the address, then a full read
    startCs();
    sendOpcOnly(8'h3B);
    for (int i = 0; i < 6; i++) step(2'b10, o, e);
    endCs();
    startCs();
    sendHeader(8'h3B, 24'h000200);
    readBytes(1);
    endCs();
    checkVal("R9", "restart after address abort", 32'(gotBytes[0]), 32'hC1);
    checkVal("R5", "quiet header after abort", 32'(cmdQuiet), 32'h1);

    // R2: the three fast-read codes give the same bytes at one address
    for (int c = 0; c < 3; c++) begin
      startCs();
      sendHeader((c == 0) ? 8'h0B : ((c == 1) ? 8'h3B : 8'hBB), 24'h0002A7);
      readBytes(2);
      endCs();
      checkVal("R2", "code equivalence byte 0", 32'(gotBytes[0]), 32'(modelMain(24'h0002A7)));
      checkVal("R2", "code equivalence byte 1", 32'(gotBytes[1]), 32'(modelMain(24'h0002A8)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule